// File: doc/BRIEF.md
# Stack Pointer Unit with Byte and Return-Address Stepping

This block keeps the stack-top address for a small 8-bit processor whose stack grows toward lower addresses. The decoder raises one strobe per cycle to name the stack event (data push, data pop, return-address save on a call or interrupt entry, or return-address restore). The block then drives the data-memory address and the read or write strobe for each byte moved, and it steps the pointer to match. A data byte moves in one cycle. A return address takes two back-to-back cycles, and `busy` is high during the second one.

Software sees the pointer as two byte-wide I/O registers, selected by `io_sel`. The number of implemented pointer bits, `PTR_BITS`, can be set anywhere from 8 to 16. High-byte bits above that width always read as zero and drop writes. With `PTR_BITS` = 8 the whole high byte is absent. The block keeps whatever value software loads. It does not check that the stack area is placed sensibly.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0, `busy` is low, and neither memory strobe is active.
- R2: A push (`ev_push`) writes `push_data` at the current pointer in the same cycle, and the pointer then drops by 1.
- R3: A pop (`ev_pop`) reads from pointer+1 in the same cycle, and the pointer then rises by 1.
- R4: A save (`ev_call`) writes `ret_addr[7:0]` at the pointer in the first cycle and `ret_addr[15:8]` at pointer-1 in the next cycle. `busy` is high in that second cycle, and the pointer ends 2 lower.
- R5: A restore (`ev_ret`) reads pointer+1 (the high byte) in the first cycle and pointer+2 (the low byte) in the next. `busy` is high in the second cycle, and the pointer ends 2 higher.
- R6: All pointer and address arithmetic wraps modulo 2^PTR_BITS.
- R7: `io_rdata` returns pointer bits 7:0 when `io_sel`=0 and bits 15:8 when `io_sel`=1. Bits at or above PTR_BITS read as 0.
- R8: When `io_we`=1, `io_wdata` replaces the selected byte of the pointer at the next edge. Bits at or above PTR_BITS are dropped, so with PTR_BITS=8 a high-byte write leaves the pointer unchanged.
- R9: If a software write and a stack event fall in the same cycle, the pointer takes the written value. The memory access of that cycle is still issued, and any second cycle uses the written pointer.
- R10: If several event strobes rise together, the priority is save > restore > push > pop. Event strobes seen while `busy` is high are ignored. `mem_we` and `mem_re` are never active together. `mem_wdata` is 0 whenever `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_push | input | 1 | Data byte push strobe |
| ev_pop | input | 1 | Data byte pop strobe |
| ev_call | input | 1 | Return-address save strobe (call or interrupt entry) |
| ev_ret | input | 1 | Return-address restore strobe |
| push_data | input | 8 | Byte to store on a push |
| ret_addr | input | 16 | Return address to store on a save |
| io_we | input | 1 | Software write to the pointer |
| io_sel | input | 1 | Byte select: 0 low, 1 high |
| io_wdata | input | 8 | Software write byte |
| io_rdata | output | 8 | Selected pointer byte |
| mem_addr | output | PTR_BITS | Data-memory address of this cycle's access |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| mem_wdata | output | 8 | Data-memory write byte |
| busy | output | 1 | Second cycle of a two-byte transfer |

## Verification
The bench drives two copies of the block with the same stimulus, one built with PTR_BITS=12 and one with PTR_BITS=8. The 12-bit copy has a partial high byte, so it shows the dropped and zero-reading upper bits. The 8-bit copy has no high byte at all, and it reaches the wrap past zero and past 0xFF with only a few pushes. Both copies are compared every cycle against a behavioural model, under directed sequences and then a long stretch of random events mixed with software writes.

// File: rtl/spu_pkg.sv
package spu_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAVE_HI = 2'd1,
        PH_LOAD_LO = 2'd2
    } phase_e;
endpackage

// File: rtl/spu_stepper.sv
module spu_stepper #(
    parameter int W = 16
) (
    input  logic [W-1:0] sp_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);
    localparam logic [W-1:0] ONE = W'(1);

    // both neighbours are always available; the sequencer picks one
    always_comb begin
        inc_o = sp_i + ONE;
        dec_o = sp_i - ONE;
    end
endmodule

// File: rtl/spu_io_port.sv
module spu_io_port #(
    parameter int W = 16
) (
    input  logic [W-1:0] sp_i,
    input  logic         sel_i,
    input  logic [7:0]   wdata_i,
    output logic [7:0]   rdata_o,
    output logic [W-1:0] wr_val_o
);
    generate
        if (W > 8) begin : g_has_hi
            localparam int HB = W - 8;
            logic [7:0] hi_ext;
            always_comb begin
                hi_ext   = 8'(sp_i[W-1:8]);
                rdata_o  = sel_i ? hi_ext : sp_i[7:0];
                wr_val_o = sel_i ? {wdata_i[HB-1:0], sp_i[7:0]}
                                 : {sp_i[W-1:8], wdata_i};
            end
        end else begin : g_no_hi
            always_comb begin
                rdata_o  = sel_i ? 8'h00 : sp_i[7:0];
                wr_val_o = sel_i ? sp_i : W'(wdata_i);
            end
        end
    endgenerate
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import spu_pkg::*;
#(
    parameter int PTR_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_push,
    input  logic                ev_pop,
    input  logic                ev_call,
    input  logic                ev_ret,
    input  logic [7:0]          push_data,
    input  logic [15:0]         ret_addr,
    input  logic                io_we,
    input  logic                io_sel,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    output logic [PTR_BITS-1:0] mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [7:0]          mem_wdata,
    output logic                busy
);
    localparam int W = PTR_BITS;
    localparam logic [7:0] HI_KEEP = (W >= 16) ? 8'hFF : 8'((1 << (W - 8)) - 1);

    typedef struct packed {
        logic [W-1:0] sp;
        phase_e       ph;
        logic [7:0]   hi;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] sp_inc, sp_dec, sw_val;
    logic         go_down, go_up, use_inc;

    spu_stepper #(.W(W)) u_step (
        .sp_i (st_q.sp),
        .inc_o(sp_inc),
        .dec_o(sp_dec)
    );

    spu_io_port #(.W(W)) u_io (
        .sp_i    (st_q.sp),
        .sel_i   (io_sel),
        .wdata_i (io_wdata),
        .rdata_o (io_rdata),
        .wr_val_o(sw_val)
    );

    always_comb begin
        st_d      = st_q;
        go_down   = 1'b0;
        go_up     = 1'b0;
        use_inc   = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = 8'h00;
        case (st_q.ph)
            PH_SAVE_HI: begin
                mem_we    = 1'b1;
                mem_wdata = st_q.hi;
                go_down   = 1'b1;
                st_d.ph   = PH_IDLE;
            end
            PH_LOAD_LO: begin
                mem_re  = 1'b1;
                use_inc = 1'b1;
                go_up   = 1'b1;
                st_d.ph = PH_IDLE;
            end
            default: begin
                if (ev_call) begin
                    mem_we    = 1'b1;
                    mem_wdata = ret_addr[7:0];
                    go_down   = 1'b1;
                    st_d.ph   = PH_SAVE_HI;
                    st_d.hi   = ret_addr[15:8];
                end else if (ev_ret) begin
                    mem_re  = 1'b1;
                    use_inc = 1'b1;
                    go_up   = 1'b1;
                    st_d.ph = PH_LOAD_LO;
                end else if (ev_push) begin
                    mem_we    = 1'b1;
                    mem_wdata = push_data;
                    go_down   = 1'b1;
                end else if (ev_pop) begin
                    mem_re  = 1'b1;
                    use_inc = 1'b1;
                    go_up   = 1'b1;
                end
            end
        endcase
        mem_addr = use_inc ? sp_inc : st_q.sp;
        if (io_we)        st_d.sp = sw_val;
        else if (go_down) st_d.sp = sp_dec;
        else if (go_up)   st_d.sp = sp_inc;
        busy = (st_q.ph != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp <= '0;
            st_q.ph <= PH_IDLE;
            st_q.hi <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: strobes exclusive
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R4, R5: second cycle lasts one cycle only
    p_busy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_push && !ev_call && !ev_ret && !io_we)
        |=> (st_q.sp == $past(st_q.sp) - 1'b1));
    p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_pop && !ev_push && !ev_call && !ev_ret && !io_we)
        |=> (st_q.sp == $past(st_q.sp) + 1'b1));
    p_save_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_call && !io_we)
        |=> (busy && mem_we && mem_addr == $past(mem_addr) - 1'b1));
    p_load_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_ret && !ev_call && !io_we)
        |=> (busy && mem_re && mem_addr == $past(mem_addr) + 1'b1));
    p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> ((io_rdata & ~HI_KEEP) == 8'h00));
    p_sw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && !io_sel) |=> (st_q.sp[7:0] == $past(io_wdata)));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
    localparam int WA = 12;
    localparam int WB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_push = 0, ev_pop = 0, ev_call = 0, ev_ret = 0;
    logic [7:0]  push_data = 0;
    logic [15:0] ret_addr = 0;
    logic io_we = 0, io_sel = 0;
    logic [7:0] io_wdata = 0;

    logic [7:0]    rd_a, wd_a, rd_b, wd_b;
    logic [WA-1:0] addr_a;
    logic [WB-1:0] addr_b;
    logic we_a, re_a, busy_a, we_b, re_b, busy_b;

    always #2 clk = ~clk;

    stack_ptr_unit #(.PTR_BITS(WA)) dut (
        .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_pop(ev_pop),
        .ev_call(ev_call), .ev_ret(ev_ret), .push_data(push_data),
        .ret_addr(ret_addr), .io_we(io_we), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(rd_a), .mem_addr(addr_a),
        .mem_we(we_a), .mem_re(re_a), .mem_wdata(wd_a), .busy(busy_a));

    stack_ptr_unit #(.PTR_BITS(WB)) dut_small (
        .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_pop(ev_pop),
        .ev_call(ev_call), .ev_ret(ev_ret), .push_data(push_data),
        .ret_addr(ret_addr), .io_we(io_we), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(rd_b), .mem_addr(addr_b),
        .mem_we(we_b), .mem_re(re_b), .mem_wdata(wd_b), .busy(busy_b));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int m_sp[2];
    int m_pend[2];   // 0 none, 1 high byte still to write, 2 low byte still to read
    int m_hi[2];

    function automatic int wmask(int i);
        return (i == 0) ? ((1 << WA) - 1) : ((1 << WB) - 1);
    endfunction

    task automatic check_one(string tag, int i, int a_addr, bit a_we, bit a_re,
                             int a_wd, bit a_busy, int a_rd);
        int msk, e_addr, e_wd, e_rd, step, nxt;
        bit e_we, e_re, e_busy, bad;
        msk = wmask(i);
        e_addr = 0; e_wd = 0; e_we = 0; e_re = 0; step = 0;
        e_busy = (m_pend[i] != 0);
        if (m_pend[i] == 1) begin
            e_we = 1; e_addr = m_sp[i]; e_wd = m_hi[i]; step = -1; m_pend[i] = 0;
        end else if (m_pend[i] == 2) begin
            e_re = 1; e_addr = (m_sp[i] + 1) & msk; step = 1; m_pend[i] = 0;
        end else if (ev_call) begin
            e_we = 1; e_addr = m_sp[i]; e_wd = ret_addr[7:0]; step = -1;
            m_pend[i] = 1; m_hi[i] = ret_addr[15:8];
        end else if (ev_ret) begin
            e_re = 1; e_addr = (m_sp[i] + 1) & msk; step = 1; m_pend[i] = 2;
        end else if (ev_push) begin
            e_we = 1; e_addr = m_sp[i]; e_wd = push_data; step = -1;
        end else if (ev_pop) begin
            e_re = 1; e_addr = (m_sp[i] + 1) & msk; step = 1;
        end
        e_rd = io_sel ? ((m_sp[i] >> 8) & 255) : (m_sp[i] & 255);
        bad = (a_we != e_we) || (a_re != e_re) || (a_busy != e_busy) ||
              (a_rd != e_rd) || (a_wd != e_wd) ||
              ((e_we || e_re) && (a_addr != e_addr));
        n_cmp++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s inst%0d: got addr=%0h we=%0b re=%0b wd=%0h busy=%0b rd=%0h, exp addr=%0h we=%0b re=%0b wd=%0h busy=%0b rd=%0h",
                     tag, i, a_addr, a_we, a_re, a_wd, a_busy, a_rd,
                     e_addr, e_we, e_re, e_wd, e_busy, e_rd);
        end
        if (io_we) begin
            if (io_sel) nxt = ((int'(io_wdata) << 8) | (m_sp[i] & 255)) & msk;
            else        nxt = (m_sp[i] & ~255) | int'(io_wdata);
        end else begin
            nxt = (m_sp[i] + step) & msk;
        end
        m_sp[i] = nxt;
    endtask

    task automatic cyc(string tag, bit pu, bit po, bit ca, bit rt, int pd, int ra,
                       bit we, bit sel, int wd);
        @(negedge clk);
        ev_push = pu; ev_pop = po; ev_call = ca; ev_ret = rt;
        push_data = 8'(pd); ret_addr = 16'(ra);
        io_we = we; io_sel = sel; io_wdata = 8'(wd);
        #1;
        check_one(tag, 0, int'(addr_a), we_a, re_a, int'(wd_a), busy_a, int'(rd_a));
        check_one(tag, 1, int'(addr_b), we_b, re_b, int'(wd_b), busy_b, int'(rd_b));
    endtask

    task automatic idle(string tag, bit sel);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, sel, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got running, exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_sp[i] = 0; m_pend[i] = 0; m_hi[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1", 0);
        idle("R1", 1);
        // R8: software load, upper bits dropped; R7 readback
        cyc("R8", 0, 0, 0, 0, 0, 0, 1, 0, 'h80);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1, 1, 'hF5);
        idle("R7", 1);
        idle("R7", 0);
        // R2 pushes, R3 pops
        cyc("R2", 1, 0, 0, 0, 'h11, 0, 0, 0, 0);
        cyc("R2", 1, 0, 0, 0, 'h22, 0, 0, 0, 0);
        cyc("R2", 1, 0, 0, 0, 'h33, 0, 0, 1, 0);
        cyc("R3", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R3", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R4 save, R5 restore
        cyc("R4", 0, 0, 1, 0, 0, 'hBEEF, 0, 0, 0);
        idle("R4", 0);
        cyc("R5", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        idle("R5", 0);
        // R10: priority and events during busy
        cyc("R10", 1, 0, 1, 0, 'h44, 'h1234, 0, 0, 0);
        cyc("R10", 1, 0, 0, 0, 'h55, 0, 0, 0, 0);
        cyc("R10", 0, 1, 0, 1, 0, 0, 0, 0, 0);
        cyc("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        // R9: software write with an event
        cyc("R9", 1, 0, 0, 0, 'h66, 0, 1, 0, 'h90);
        idle("R9", 0);
        cyc("R9", 0, 0, 1, 0, 0, 'hA5C3, 1, 0, 'h70);
        idle("R9", 0);
        // R6: wrap both ways
        cyc("R6", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        cyc("R6", 1, 0, 0, 0, 'h77, 0, 0, 0, 0);
        idle("R6", 1);
        cyc("R6", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R6", 0, 0, 1, 0, 0, 'h0102, 0, 0, 0);
        idle("R6", 1);
        cyc("R6", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        idle("R6", 0);
        // R8: high-byte write on both widths
        cyc("R8", 0, 0, 0, 0, 0, 0, 1, 1, 'hFF);
        idle("R8", 1);
        // R10: random mix
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom;
            cyc("R10", r[0], r[1], r[2] & r[3], r[4] & r[5], $urandom & 255,
                $urandom & 'hFFFF, (r[11:8] == 4'h0), r[12], $urandom & 255);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule